// File: doc/BRIEF.md
# Locomotive Instruction Byte Encoder

This block turns one locomotive command into the instruction bytes that follow the address byte of a track packet. A command is one of four operations: a signed speed in a chosen step format, a function group update, a write to a decoder configuration variable, or an emergency stop. The block returns up to three data bytes, how many of them are in use, and a packet kind that a downstream scheduler uses to sort the result into its queues. The address byte and the trailing check byte are added further down the chain.

The encoder is one registered stage. A command presented with `in_valid` high at a rising edge appears on the outputs after that edge, together with a one-cycle `out_valid` pulse. A command that cannot be encoded raises `out_err` for one cycle instead. The speed-to-step scaling is either computed with a divider or looked up in a table derived at elaboration. A parameter picks which one, and both give the same results.

Top module: `loco_instr_encoder`

## Requirements
- R1: After a cycle with `rst` high, `out_valid` and `out_err` are 0, `out_count` is 0, `out_kind` is 0 and `out_bytes` is 0.
- R2: A command sampled with `in_valid` high at a rising edge is shown at the outputs after that same edge. A cycle with `in_valid` low gives `out_valid` = 0 and `out_err` = 0 after the next edge.
- R3: With `in_op` = 0 (speed) and a valid step format, a speed of 0 yields one byte, 0x41, with kind 6 (addressed stop). A magnitude of 1 is a normal stop, which encodes a speed field of 0.
- R4: With `in_steps` = 2 (128 steps), the output is two bytes. Byte 0 is 0x3F. Byte 1 has bit 7 set for forward (a positive speed) and the magnitude in bits 6..0. The count is 2 and the kind is 1 (speed).
- R5: With `in_steps` = 1 (28 steps), the output is one byte, 0x40, with bit 5 set for forward. A motion level f in 2..31 is placed as f[0] at bit 4 and f[4:1] at bits 3..0. The kind is 1.
- R6: With `in_steps` = 0 (14 steps), the output is one byte, 0x40, with bit 5 set for forward and a motion level in 2..15 in bits 3..0. The kind is 1.
- R7: A motion magnitude m in 2..127 maps to the level (m−2)·(max−2)/125 + 2, truncated, where max is 15 for 14 steps and 31 for 28 steps. A speed of −128 is treated as magnitude 127, reverse.
- R8: With `in_op` = 1, `in_fgroup` = 0 gives 0x80 with F0 (`in_fbits[0]`) at bit 4 and F1..F4 (`in_fbits[4:1]`) at bits 3..0, kind 2. Group 1 gives 0xB0 with `in_fbits[3:0]`, kind 3. Group 2 gives 0xA0 with `in_fbits[3:0]`, kind 4. In groups 1 and 2, `in_fbits[4]` is ignored.
- R9: With `in_op` = 2, the output is three bytes, and k = (`in_cv` − 1) mod 1024. Byte 0 is 0xEC with k[9:8] in bits 1..0, byte 1 is k[7:0], byte 2 is `in_cv_data`. The kind is 5.
- R10: With `in_op` = 3, a stop with `in_bcast` high yields 0x71 with kind 7, and one with `in_bcast` low yields 0x41 with kind 6. In both cases the count is 1.
- R11: A speed command with `in_steps` = 3, or a function command with `in_fgroup` = 3, gives `out_err` = 1, `out_valid` = 0, count 0, kind 0 and all bytes 0.
- R12: Byte lanes beyond `out_count` are 0. Byte 0 is in `out_bytes[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command present this cycle |
| in_op | input | 2 | 0 speed, 1 function group, 2 CV write, 3 emergency stop |
| in_speed | input | 8 | Signed speed, two's complement |
| in_steps | input | 2 | 0 = 14, 1 = 28, 2 = 128 steps, 3 unsupported |
| in_fgroup | input | 2 | Function group 0..2, 3 unsupported |
| in_fbits | input | 5 | Function states |
| in_cv | input | CV_W (11) | Configuration variable number, 1-based |
| in_cv_data | input | 8 | Value to write |
| in_bcast | input | 1 | Emergency stop for all locomotives |
| out_valid | output | 1 | Encoded result present |
| out_err | output | 1 | Command rejected |
| out_bytes | output | 24 | Data bytes, byte 0 lowest |
| out_count | output | 2 | Number of bytes in use |
| out_kind | output | 3 | Packet kind code |

## Verification
All state lives in one output register, so an internal fault shows up on the ports in the cycle right after the command that exposes it. There is no later point at which it could appear. A wrong scaling entry affects only the magnitudes that land on it, so the bench sweeps every magnitude in both directions for both scaled formats. A bit-placement slip, such as F0 or the rotated low speed bit, shows up as a single wrong bit in a one-byte result. A rejected command that leaks data shows up as nonzero bytes or a count beside `out_err`.

// File: rtl/loco_enc_pkg.sv
package loco_enc_pkg;

  typedef enum logic [1:0] {
    OP_SPEED = 2'd0,
    OP_FUNC  = 2'd1,
    OP_CVWR  = 2'd2,
    OP_STOP  = 2'd3
  } loco_op_e;

  typedef enum logic [2:0] {
    KIND_NONE     = 3'd0,
    KIND_SPEED    = 3'd1,
    KIND_FG1      = 3'd2,
    KIND_FG2      = 3'd3,
    KIND_FG3      = 3'd4,
    KIND_CVWR     = 3'd5,
    KIND_STOP_ONE = 3'd6,
    KIND_STOP_ALL = 3'd7
  } loco_kind_e;

  localparam int MAG_W    = 7;
  localparam int LEVEL_W  = 5;
  localparam int MAG_SPAN = 125;

endpackage

// File: rtl/loco_speed_scaler.sv
module loco_speed_scaler
  import loco_enc_pkg::*;
#(
  parameter int OUT_MAX   = 15,
  parameter bit USE_TABLE = 1'b0
) (
  input  logic [MAG_W-1:0]   mag,
  output logic [LEVEL_W-1:0] level
);
  localparam int ENTRIES = 1 << MAG_W;
  localparam int NUMER   = OUT_MAX - 2;

  generate
    if (USE_TABLE) begin : g_tbl
      logic [LEVEL_W-1:0] tbl [ENTRIES];
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign tbl[i] = (i < 2) ? '0 : LEVEL_W'(((i - 2) * NUMER) / MAG_SPAN + 2);
      end
      assign level = tbl[mag];
    end else begin : g_div
      logic [11:0] off;
      logic [11:0] prod;
      logic [11:0] quo;
      always_comb begin
        off  = {5'd0, mag} - 12'd2;
        prod = off * 12'(NUMER);
        quo  = prod / 12'(MAG_SPAN);
        level = (mag >= MAG_W'(2)) ? (quo[LEVEL_W-1:0] + LEVEL_W'(2)) : '0;
      end
    end
  endgenerate

  always_comb begin
    if (mag >= MAG_W'(2)) begin
      AST_SCALE_RANGE: assert (int'(level) >= 2 && int'(level) <= OUT_MAX); // R7
    end
  end

endmodule

// File: rtl/loco_speed_enc.sv
module loco_speed_enc
  import loco_enc_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  logic [7:0] speed,
  input  logic [1:0] steps,
  output logic [7:0] b0,
  output logic [7:0] b1,
  output logic [1:0] count,
  output logic       is_stop,
  output logic       bad_mode
);
  logic [7:0]         absv;
  logic [MAG_W-1:0]   mag;
  logic               fwd;
  logic               moving;
  logic [LEVEL_W-1:0] lvl14;
  logic [LEVEL_W-1:0] lvl28;
  logic [LEVEL_W-1:0] f28;

  always_comb begin
    absv   = speed[7] ? (~speed + 8'd1) : speed;
    mag    = absv[7] ? {MAG_W{1'b1}} : absv[MAG_W-1:0];
    fwd    = ~speed[7];
    moving = (mag >= MAG_W'(2));
  end

  loco_speed_scaler #(.OUT_MAX(15), .USE_TABLE(USE_TABLE)) u_scale14 (
    .mag(mag), .level(lvl14)
  );
  loco_speed_scaler #(.OUT_MAX(31), .USE_TABLE(USE_TABLE)) u_scale28 (
    .mag(mag), .level(lvl28)
  );

  always_comb begin
    b0       = 8'd0;
    b1       = 8'd0;
    count    = 2'd1;
    is_stop  = 1'b0;
    bad_mode = 1'b0;
    f28      = moving ? lvl28 : '0;
    case (steps)
      2'd0: b0 = {2'b01, fwd, 1'b0, (moving ? lvl14[3:0] : 4'd0)};
      2'd1: b0 = {2'b01, fwd, f28[0], f28[4:1]};
      2'd2: begin
        b0    = 8'h3F;
        b1    = {fwd, (moving ? mag : MAG_W'(0))};
        count = 2'd2;
      end
      default: begin
        bad_mode = 1'b1;
        count    = 2'd0;
      end
    endcase
    if (!bad_mode && speed == 8'd0) begin
      b0      = 8'h41;
      b1      = 8'd0;
      count   = 2'd1;
      is_stop = 1'b1;
    end
  end

endmodule

// File: rtl/loco_func_enc.sv
module loco_func_enc
  import loco_enc_pkg::*;
(
  input  logic [1:0] group,
  input  logic [4:0] fbits,
  output logic [7:0] fbyte,
  output loco_kind_e kind,
  output logic       bad_group
);
  always_comb begin
    fbyte     = 8'd0;
    kind      = KIND_NONE;
    bad_group = 1'b0;
    case (group)
      2'd0: begin
        fbyte = {3'b100, fbits[0], fbits[4:1]};
        kind  = KIND_FG1;
      end
      2'd1: begin
        fbyte = {4'hB, fbits[3:0]};
        kind  = KIND_FG2;
      end
      2'd2: begin
        fbyte = {4'hA, fbits[3:0]};
        kind  = KIND_FG3;
      end
      default: bad_group = 1'b1;
    endcase
  end
endmodule

// File: rtl/loco_instr_encoder.sv
module loco_instr_encoder
  import loco_enc_pkg::*;
#(
  parameter int CV_W      = 11,
  parameter bit USE_TABLE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [7:0]      in_speed,
  input  logic [1:0]      in_steps,
  input  logic [1:0]      in_fgroup,
  input  logic [4:0]      in_fbits,
  input  logic [CV_W-1:0] in_cv,
  input  logic [7:0]      in_cv_data,
  input  logic            in_bcast,
  output logic            out_valid,
  output logic            out_err,
  output logic [23:0]     out_bytes,
  output logic [1:0]      out_count,
  output logic [2:0]      out_kind
);
  localparam int NBYTES = 3;
  localparam int IDX_W  = 10;

  loco_op_e   op;
  logic [7:0] sp_b0, sp_b1;
  logic [1:0] sp_cnt;
  logic       sp_stop, sp_bad;
  logic [7:0] fn_byte;
  loco_kind_e fn_kind;
  logic       fn_bad;
  logic [CV_W-1:0] cv_m1;

  logic [8*NBYTES-1:0] nxt_bytes;
  logic [1:0]          nxt_cnt;
  loco_kind_e          nxt_kind;
  logic                nxt_bad;

  assign op = loco_op_e'(in_op);

  loco_speed_enc #(.USE_TABLE(USE_TABLE)) u_speed (
    .speed(in_speed), .steps(in_steps), .b0(sp_b0), .b1(sp_b1),
    .count(sp_cnt), .is_stop(sp_stop), .bad_mode(sp_bad)
  );

  loco_func_enc u_func (
    .group(in_fgroup), .fbits(in_fbits), .fbyte(fn_byte),
    .kind(fn_kind), .bad_group(fn_bad)
  );

  always_comb begin
    cv_m1     = in_cv - CV_W'(1);
    nxt_bytes = '0;
    nxt_cnt   = 2'd0;
    nxt_kind  = KIND_NONE;
    nxt_bad   = 1'b0;
    case (op)
      OP_SPEED: begin
        if (sp_bad) begin
          nxt_bad = 1'b1;
        end else if (sp_stop) begin
          nxt_bytes = {16'd0, sp_b0};
          nxt_cnt   = 2'd1;
          nxt_kind  = KIND_STOP_ONE;
        end else begin
          nxt_bytes = {8'd0, sp_b1, sp_b0};
          nxt_cnt   = sp_cnt;
          nxt_kind  = KIND_SPEED;
        end
      end
      OP_FUNC: begin
        if (fn_bad) begin
          nxt_bad = 1'b1;
        end else begin
          nxt_bytes = {16'd0, fn_byte};
          nxt_cnt   = 2'd1;
          nxt_kind  = fn_kind;
        end
      end
      OP_CVWR: begin
        nxt_bytes = {in_cv_data, cv_m1[7:0], 6'b111011, cv_m1[IDX_W-1:8]};
        nxt_cnt   = 2'd3;
        nxt_kind  = KIND_CVWR;
      end
      default: begin
        nxt_bytes = {16'd0, (in_bcast ? 8'h71 : 8'h41)};
        nxt_cnt   = 2'd1;
        nxt_kind  = in_bcast ? KIND_STOP_ALL : KIND_STOP_ONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_bytes <= '0;
      out_count <= 2'd0;
      out_kind  <= 3'd0;
    end else begin
      out_valid <= in_valid & ~nxt_bad;
      out_err   <= in_valid & nxt_bad;
      if (in_valid) begin
        out_bytes <= nxt_bytes;
        out_count <= nxt_cnt;
        out_kind  <= nxt_kind;
      end
    end
  end

  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (!out_valid && out_count == 2'd0 && out_bytes == '0)); // R11
  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_err) |-> $past(in_valid)); // R2
  AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind >= 3'd6) |-> out_count == 2'd1); // R10
  AST_CV_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 3'd5) |-> (out_bytes[7:2] == 6'b111011 && out_count == 2'd3)); // R9
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_count == 2'd1) |-> out_bytes[23:8] == 16'd0); // R12

endmodule

// File: tb/loco_instr_encoder_tb_top.sv
module loco_instr_encoder_tb_top;
  localparam int CV_W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [7:0] in_speed = '0;
  logic [1:0] in_steps = '0;
  logic [1:0] in_fgroup = '0;
  logic [4:0] in_fbits = '0;
  logic [CV_W-1:0] in_cv = '0;
  logic [7:0] in_cv_data = '0;
  logic in_bcast = 1'b0;
  logic out_valid, out_err;
  logic [23:0] out_bytes;
  logic [1:0] out_count;
  logic [2:0] out_kind;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loco_instr_encoder #(.CV_W(CV_W), .USE_TABLE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_speed(in_speed), .in_steps(in_steps), .in_fgroup(in_fgroup),
    .in_fbits(in_fbits), .in_cv(in_cv), .in_cv_data(in_cv_data),
    .in_bcast(in_bcast), .out_valid(out_valid), .out_err(out_err),
    .out_bytes(out_bytes), .out_count(out_count), .out_kind(out_kind)
  );

  // packed result: {valid, err, kind[2:0], count[1:0], bytes[23:0]}
  function automatic logic [30:0] pk(logic v, logic e, logic [2:0] k, logic [1:0] c, logic [23:0] b);
    return {v, e, k, c, b};
  endfunction

  task automatic chk(string req, logic [30:0] got, logic [30:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [30:0] observed();
    return pk(out_valid, out_err, out_kind, out_count, out_bytes);
  endfunction

  task automatic issue(logic [1:0] op, logic [7:0] sp, logic [1:0] st, logic [1:0] grp,
                       logic [4:0] fb, logic [CV_W-1:0] cv, logic [7:0] cd, logic bc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_speed = sp; in_steps = st; in_fgroup = grp;
    in_fbits = fb; in_cv = cv; in_cv_data = cd; in_bcast = bc;
    @(posedge clk);
    #1;
  endtask

  task automatic speed(logic [7:0] sp, logic [1:0] st);
    issue(2'd0, sp, st, 2'd0, 5'd0, '0, 8'd0, 1'b0);
  endtask

  function automatic int lvl(int m, int mx);
    return (m - 2) * (mx - 2) / 125 + 2;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", observed(), pk(0, 0, 3'd0, 2'd0, 24'd0));
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_speed128();
    speed(8'd1, 2'd2);    chk("R3 R4 stop fwd 128", observed(), pk(1, 0, 3'd1, 2'd2, 24'h00803F));
    speed(-8'sd1, 2'd2);  chk("R3 R4 stop rev 128", observed(), pk(1, 0, 3'd1, 2'd2, 24'h00003F));
    speed(8'd100, 2'd2);  chk("R4 fwd 100", observed(), pk(1, 0, 3'd1, 2'd2, 24'h00E43F));
    speed(-8'sd127, 2'd2); chk("R4 rev 127", observed(), pk(1, 0, 3'd1, 2'd2, 24'h007F3F));
    speed(8'h80, 2'd2);   chk("R7 saturate -128", observed(), pk(1, 0, 3'd1, 2'd2, 24'h007F3F));
    speed(8'd2, 2'd2);    chk("R4 fwd 2", observed(), pk(1, 0, 3'd1, 2'd2, 24'h00823F));
  endtask

  task automatic t_stop_codes();
    speed(8'd0, 2'd0); chk("R3 zero 14", observed(), pk(1, 0, 3'd6, 2'd1, 24'h41));
    speed(8'd0, 2'd1); chk("R3 zero 28", observed(), pk(1, 0, 3'd6, 2'd1, 24'h41));
    speed(8'd0, 2'd2); chk("R3 zero 128", observed(), pk(1, 0, 3'd6, 2'd1, 24'h41));
    speed(8'd1, 2'd1); chk("R3 R5 stop fwd 28", observed(), pk(1, 0, 3'd1, 2'd1, 24'h60));
    speed(-8'sd1, 2'd0); chk("R3 R6 stop rev 14", observed(), pk(1, 0, 3'd1, 2'd1, 24'h40));
  endtask

  task automatic t_sweep();
    for (int m = 2; m <= 127; m++) begin
      for (int d = 0; d < 2; d++) begin
        logic [7:0] sp;
        logic [4:0] f;
        logic [7:0] e;
        sp = (d == 1) ? 8'(m) : 8'(-m);
        f = 5'(lvl(m, 15));
        e = {2'b01, 1'(d), 1'b0, f[3:0]};
        speed(sp, 2'd0);
        chk("R6 R7 sweep 14", observed(), pk(1, 0, 3'd1, 2'd1, {16'd0, e}));
        f = 5'(lvl(m, 31));
        e = {2'b01, 1'(d), f[0], f[4:1]};
        speed(sp, 2'd1);
        chk("R5 R7 sweep 28", observed(), pk(1, 0, 3'd1, 2'd1, {16'd0, e}));
      end
    end
    speed(8'd7, 2'd1);    chk("R5 fwd 7 rotated", observed(), pk(1, 0, 3'd1, 2'd1, 24'h71));
    speed(8'd127, 2'd0);  chk("R6 fwd 127", observed(), pk(1, 0, 3'd1, 2'd1, 24'h6F));
  endtask

  task automatic t_func();
    issue(2'd1, 8'd0, 2'd0, 2'd0, 5'b00001, '0, 8'd0, 1'b0);
    chk("R8 F0 at bit4", observed(), pk(1, 0, 3'd2, 2'd1, 24'h90));
    issue(2'd1, 8'd0, 2'd0, 2'd0, 5'b11110, '0, 8'd0, 1'b0);
    chk("R8 F1-F4", observed(), pk(1, 0, 3'd2, 2'd1, 24'h8F));
    issue(2'd1, 8'd0, 2'd0, 2'd1, 5'b11010, '0, 8'd0, 1'b0);
    chk("R8 group two bit4 ignored", observed(), pk(1, 0, 3'd3, 2'd1, 24'hBA));
    issue(2'd1, 8'd0, 2'd0, 2'd2, 5'b10101, '0, 8'd0, 1'b0);
    chk("R8 group three", observed(), pk(1, 0, 3'd4, 2'd1, 24'hA5));
  endtask

  task automatic t_cv();
    issue(2'd2, 8'd0, 2'd0, 2'd0, 5'd0, 11'd1, 8'h5A, 1'b0);
    chk("R9 cv 1", observed(), pk(1, 0, 3'd5, 2'd3, 24'h5A00EC));
    issue(2'd2, 8'd0, 2'd0, 2'd0, 5'd0, 11'd300, 8'hC3, 1'b0);
    chk("R9 cv 300", observed(), pk(1, 0, 3'd5, 2'd3, 24'hC32BED));
    issue(2'd2, 8'd0, 2'd0, 2'd0, 5'd0, 11'd1024, 8'hFF, 1'b0);
    chk("R9 cv 1024", observed(), pk(1, 0, 3'd5, 2'd3, 24'hFFFFEF));
    issue(2'd2, 8'd0, 2'd0, 2'd0, 5'd0, 11'd0, 8'h01, 1'b0);
    chk("R9 cv 0 wraps", observed(), pk(1, 0, 3'd5, 2'd3, 24'h01FFEF));
  endtask

  task automatic t_estop();
    issue(2'd3, 8'd0, 2'd0, 2'd0, 5'd0, '0, 8'd0, 1'b1);
    chk("R10 broadcast", observed(), pk(1, 0, 3'd7, 2'd1, 24'h71));
    issue(2'd3, 8'd0, 2'd0, 2'd0, 5'd0, '0, 8'd0, 1'b0);
    chk("R10 addressed", observed(), pk(1, 0, 3'd6, 2'd1, 24'h41));
  endtask

  task automatic t_bad();
    speed(8'd50, 2'd3);
    chk("R11 bad steps", observed(), pk(0, 1, 3'd0, 2'd0, 24'd0));
    speed(8'd0, 2'd3);
    chk("R11 bad steps zero speed", observed(), pk(0, 1, 3'd0, 2'd0, 24'd0));
    issue(2'd1, 8'd0, 2'd0, 2'd3, 5'h1F, '0, 8'd0, 1'b0);
    chk("R11 bad group", observed(), pk(0, 1, 3'd0, 2'd0, 24'd0));
  endtask

  task automatic t_idle();
    issue(2'd2, 8'd0, 2'd0, 2'd0, 5'd0, 11'd5, 8'h11, 1'b0);
    chk("R2 same-edge result", observed(), pk(1, 0, 3'd5, 2'd3, 24'h1104EC));
    @(negedge clk);
    in_valid = 1'b0; in_op = 2'd3; in_bcast = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 idle no pulse", {29'd0, out_valid, out_err}, 31'd0);
    @(posedge clk);
    #1;
    chk("R2 idle stays low", {29'd0, out_valid, out_err}, 31'd0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_speed128();
    t_stop_codes();
    t_sweep();
    t_func();
    t_cv();
    t_estop();
    t_bad();
    t_idle();
    summary();
  end
endmodule